// File: doc/BRIEF.md
# Pull-Driven Transmit Arbiter Between Protocol Layers

This block sits at the seam between one lower transmit layer and several upper transmit modules that share it, for example two transport modules above a network layer. Each upper module owns a FIFO and raises its empty flag while it has nothing to send. The block picks one module that has data and tells the lower layer that a payload is waiting. When the lower layer reaches the point in its own frame where the payload belongs, it pulses a next strobe. The block steers that strobe to the chosen module as its start signal. It then passes that module's enable and data downward through one register.

The upper module begins driving on the cycle after its start. Its bytes leave this block one cycle later. Each boundary therefore costs one clock and holds one byte. Nothing is stored in the layer below. Selection is round-robin. Once a start has been issued, the choice stays fixed until the chosen module drops its enable.

Top module: `pull_arb_xconnect`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `dn_pending` and `dn_en` are 0, `src_start` is all zero and `dn_data` is 0.
- R2: A source requests when its bit in `src_empty` is 0. When the block is idle and at least one source requests at a rising edge, `dn_pending` is 1 from that edge on.
- R3: The grant goes to the first requesting source found by scanning upward from a priority pointer and wrapping at N_SRC. The pointer is 0 after reset and becomes the granted index plus one, modulo N_SRC, when a transfer completes.
- R4: `src_start` is all zero except in the cycle where `dn_pending` and `dn_next` are both 1. In that cycle, only bit `grant_idx` is set, in the same cycle. `dn_next` has no effect while `dn_pending` is 0.
- R5: During a transfer, `dn_en` and `dn_data` equal the granted source's `src_en` bit and its data lane (bits `i*DATA_W +: DATA_W` of `src_data`) one cycle later. Outside a transfer, and whenever that enable is low, both outputs are 0.
- R6: The enable and data of sources that are not granted never reach `dn_en` or `dn_data`.
- R7: From the start pulse until the transfer ends, `grant_idx` does not change and `dn_pending` stays 0, even when other sources request.
- R8: A transfer ends at the first edge where the granted enable is low after it has been high. With a source still requesting, `dn_pending` rises again two cycles after the enable falls.
- R9: If the offered source raises its empty flag while `dn_pending` is 1 and `dn_next` is 0, the offer is withdrawn: `dn_pending` is 0 on the next cycle and the priority pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_empty | input | N_SRC | FIFO-empty flag per upper source; 0 means data waiting |
| src_en | input | N_SRC | Per-source transmit enable |
| src_data | input | N_SRC*DATA_W | Packed source data lanes, source i at bits i*DATA_W +: DATA_W |
| src_start | output | N_SRC | Start strobe to the granted source |
| dn_pending | output | 1 | A payload is offered to the lower layer |
| dn_next | input | 1 | Lower layer requests the payload now |
| dn_en | output | 1 | Registered enable toward the lower layer |
| dn_data | output | DATA_W | Registered data toward the lower layer |
| grant_idx | output | IDX_W | Index of the offered or transferring source |

## Verification
The assertions take for granted that a granted source holds its enable as one unbroken run after its start. They also take for granted that `dn_next` is a single-cycle strobe. The start-routing and withdrawal properties only judge `dn_next` in cycles where `dn_pending` is high. The bench keeps to these rules. It raises `dn_next` for exactly one cycle, or while idle to show that the strobe is ignored. It drives each payload as one contiguous run on the granted lane. Lanes that are not granted get junk data with their enables high, so the exclusion properties are tested against real traffic.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OFFER = 2'd1,
        PH_BUSY  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   seen_en;
    } arb_state_t;

    localparam arb_state_t ARB_RESET = '{phase: PH_IDLE, seen_en: 1'b0};

    function automatic int pa_wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    function automatic int pa_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pa_rr_pick.sv
module pa_rr_pick #(
    parameter int N_SRC = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_SRC-1:0] req,
    input  logic [IDX_W-1:0] ptr,
    output logic             any,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        any  = |req;
        pick = '0;
        for (int off = N_SRC - 1; off >= 0; off--) begin
            int cand;
            cand = int'(ptr) + off;
            if (cand >= N_SRC) cand = cand - N_SRC;
            if (req[cand]) pick = IDX_W'(cand);
        end
    end
endmodule

// File: rtl/pa_grant_fsm.sv
module pa_grant_fsm
    import pa_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic             dn_next,
    input  logic             pick_any,
    input  logic [IDX_W-1:0] pick_idx,
    output logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] gnt_idx,
    output logic [N_SRC-1:0] start,
    output logic             pending,
    output logic             fwd_active
);
    arb_state_t       st_q;
    logic [IDX_W-1:0] gnt_q;
    logic [IDX_W-1:0] ptr_q;
    logic             gnt_req;
    logic             gnt_en;

    assign gnt_req = req[gnt_q];
    assign gnt_en  = en[gnt_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ARB_RESET;
            gnt_q <= '0;
            ptr_q <= '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (pick_any) begin
                        st_q.phase <= PH_OFFER;
                        gnt_q      <= pick_idx;
                    end
                end
                PH_OFFER: begin
                    if (dn_next) begin
                        st_q.phase   <= PH_BUSY;
                        st_q.seen_en <= 1'b0;
                    end else if (!gnt_req) begin
                        st_q.phase <= PH_IDLE;
                    end
                end
                PH_BUSY: begin
                    if (gnt_en) begin
                        st_q.seen_en <= 1'b1;
                    end else if (st_q.seen_en) begin
                        st_q.phase   <= PH_IDLE;
                        st_q.seen_en <= 1'b0;
                        ptr_q        <= IDX_W'(pa_wrap_inc(int'(gnt_q), N_SRC));
                    end
                end
                default: st_q <= ARB_RESET;
            endcase
        end
    end

    assign pending    = (st_q.phase == PH_OFFER);
    assign fwd_active = (st_q.phase == PH_BUSY);
    assign gnt_idx    = gnt_q;
    assign ptr        = ptr_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_start
        assign start[i] = pending && dn_next && (gnt_q == IDX_W'(i));
    end
endmodule

// File: rtl/pa_data_stage.sv
module pa_data_stage #(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fwd_active,
    input  logic [IDX_W-1:0]        sel,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC*DATA_W-1:0] src_data,
    output logic                    dn_en,
    output logic [DATA_W-1:0]       dn_data
);
    logic [DATA_W-1:0] lane [N_SRC];
    logic              sel_en;
    logic [DATA_W-1:0] sel_data;
    logic              en_q;
    logic [DATA_W-1:0] data_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_lane
        assign lane[i] = src_data[i*DATA_W +: DATA_W];
    end

    assign sel_en   = src_en[sel];
    assign sel_data = lane[sel];

    always_ff @(posedge clk) begin
        if (rst || !(fwd_active && sel_en)) begin
            en_q   <= 1'b0;
            data_q <= '0;
        end else begin
            en_q   <= 1'b1;
            data_q <= sel_data;
        end
    end

    assign dn_en   = en_q;
    assign dn_data = data_q;
endmodule

// File: rtl/pull_arb_xconnect.sv
module pull_arb_xconnect
    import pa_pkg::*;
#(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 8,
    localparam int IDX_W = pa_idx_w(N_SRC)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        src_empty,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC*DATA_W-1:0] src_data,
    output logic [N_SRC-1:0]        src_start,
    output logic                    dn_pending,
    input  logic                    dn_next,
    output logic                    dn_en,
    output logic [DATA_W-1:0]       dn_data,
    output logic [IDX_W-1:0]        grant_idx
);
    logic [N_SRC-1:0] req;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] ptr;
    logic             fwd_active;

    assign req = ~src_empty;

    pa_rr_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) pick_i (
        .req  (req),
        .ptr  (ptr),
        .any  (pick_any),
        .pick (pick_idx)
    );

    pa_grant_fsm #(.N_SRC(N_SRC), .IDX_W(IDX_W)) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .en         (src_en),
        .dn_next    (dn_next),
        .pick_any   (pick_any),
        .pick_idx   (pick_idx),
        .ptr        (ptr),
        .gnt_idx    (grant_idx),
        .start      (src_start),
        .pending    (dn_pending),
        .fwd_active (fwd_active)
    );

    pa_data_stage #(.N_SRC(N_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) data_i (
        .clk        (clk),
        .rst        (rst),
        .fwd_active (fwd_active),
        .sel        (grant_idx),
        .src_en     (src_en),
        .src_data   (src_data),
        .dn_en      (dn_en),
        .dn_data    (dn_data)
    );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
    parameter int N_SRC = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_empty,
    input logic [N_SRC-1:0] src_en,
    input logic [N_SRC-1:0] src_start,
    input logic             dn_pending,
    input logic             dn_next,
    input logic             dn_en,
    input logic [IDX_W-1:0] grant_idx,
    input logic             xfer_active
);
    logic             sel_en_q;
    logic [N_SRC-1:0] empty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_en_q <= 1'b0;
            empty_q  <= '1;
        end else begin
            sel_en_q <= xfer_active && src_en[grant_idx];
            empty_q  <= src_empty;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dn_pending && !dn_en && src_start == '0));

    // R2
    a_r2_offer_follows_req: assert property (@(posedge clk) disable iff (rst)
        (!dn_pending && !xfer_active && !(&src_empty)) |=> dn_pending);

    // R3
    a_r3_grant_requested: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_pending) |-> !empty_q[grant_idx]);

    // R4
    a_r4_start_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_start));

    // R4
    a_r4_start_routed: assert property (@(posedge clk) disable iff (rst)
        (|src_start) |-> (dn_pending && dn_next && src_start[grant_idx]));

    // R5, R6
    a_r5_en_from_granted: assert property (@(posedge clk) disable iff (rst)
        dn_en |-> sel_en_q);

    // R7
    a_r7_grant_locked: assert property (@(posedge clk) disable iff (rst)
        (xfer_active && $past(xfer_active)) |-> ($stable(grant_idx) && !dn_pending));

    // R9
    a_r9_withdraw: assert property (@(posedge clk) disable iff (rst)
        (dn_pending && !dn_next && src_empty[grant_idx]) |=> !dn_pending);
endmodule

bind pull_arb_xconnect pa_checker #(.N_SRC(N_SRC), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .src_empty   (src_empty),
    .src_en      (src_en),
    .src_start   (src_start),
    .dn_pending  (dn_pending),
    .dn_next     (dn_next),
    .dn_en       (dn_en),
    .grant_idx   (grant_idx),
    .xfer_active (fwd_active)
);

// File: tb/pull_arb_xconnect_tb_top.sv
`timescale 1ns/1ps
module pull_arb_xconnect_tb_top;
    localparam int N = 4;
    localparam int W = 8;
    localparam int NV = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   src_empty;
    logic [N-1:0]   src_en;
    logic [N*W-1:0] src_data;
    logic [N-1:0]   src_start;
    logic           dn_pending;
    logic           dn_next;
    logic           dn_en;
    logic [W-1:0]   dn_data;
    logic [1:0]     grant_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // {empty mask, expected grant, payload length}
    localparam logic [9:0] VEC [NV] = '{
        {4'b1010, 2'd0, 4'd3},
        {4'b1010, 2'd2, 4'd1},
        {4'b1010, 2'd0, 4'd4},
        {4'b0111, 2'd3, 4'd2},
        {4'b0000, 2'd0, 4'd5},
        {4'b0000, 2'd1, 4'd2},
        {4'b1100, 2'd0, 4'd3},
        {4'b1101, 2'd1, 4'd1}
    };

    always #2.5 clk = ~clk;

    pull_arb_xconnect #(.N_SRC(N), .DATA_W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_empty  (src_empty),
        .src_en     (src_en),
        .src_data   (src_data),
        .src_start  (src_start),
        .dn_pending (dn_pending),
        .dn_next    (dn_next),
        .dn_en      (dn_en),
        .dn_data    (dn_data),
        .grant_idx  (grant_idx)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_lanes();
        src_en   = '0;
        src_data = '0;
    endtask

    task automatic do_xfer(input logic [N-1:0] empty, input int g, input int len,
                           input int tag, input bit rearm, input int next_g);
        logic [W-1:0] dv;
        src_empty = empty;
        #1;
        chk("R2 no offer before arbitration edge", 32'(dn_pending), 0);
        tick();
        chk("R2 offer after request", 32'(dn_pending), 1);
        chk("R3 round-robin grant", 32'(grant_idx), 32'(g));
        dn_next = 1'b1;
        #1;
        chk("R4 start routed to granted source", 32'(src_start), 32'(1 << g));
        tick();
        dn_next = 1'b0;
        #1;
        chk("R4 start only with next", 32'(src_start), 0);
        chk("R7 no offer during transfer", 32'(dn_pending), 0);
        for (int k = 0; k < len; k++) begin
            dv = W'(16 * tag + k + 1);
            for (int i = 0; i < N; i++) begin
                src_en[i] = 1'b1;
                src_data[i*W +: W] = (i == g) ? dv : W'(8'hE0 + i);
            end
            tick();
            chk("R5 enable forwarded", 32'(dn_en), 1);
            chk("R5 R6 data from granted lane only", 32'(dn_data), 32'(dv));
            chk("R7 grant held", 32'(grant_idx), 32'(g));
        end
        idle_lanes();
        if (!rearm) src_empty = '1;
        tick();
        chk("R5 enable low after transfer", 32'(dn_en), 0);
        chk("R5 data zero after transfer", 32'(dn_data), 0);
        chk("R8 idle one cycle after enable drop", 32'(dn_pending), 0);
        if (rearm) begin
            tick();
            chk("R8 next offer two cycles after drop", 32'(dn_pending), 1);
            chk("R8 R3 pointer advanced", 32'(grant_idx), 32'(next_g));
            src_empty = '1;
            tick();
            chk("R9 withdrawn offer drops", 32'(dn_pending), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst       = 1'b1;
        src_empty = '1;
        dn_next   = 1'b0;
        idle_lanes();
        repeat (3) tick();
        chk("R1 pending low in reset", 32'(dn_pending), 0);
        chk("R1 enable low in reset", 32'(dn_en), 0);
        rst = 1'b0;
        tick();
        chk("R1 pending low after reset", 32'(dn_pending), 0);
        chk("R1 enable low after reset", 32'(dn_en), 0);
        chk("R1 data zero after reset", 32'(dn_data), 0);
        chk("R1 start low after reset", 32'(src_start), 0);

        for (int v = 0; v < NV; v++) begin
            do_xfer(VEC[v][9:6], int'(VEC[v][5:4]), int'(VEC[v][3:0]), v, 1'b0, 0);
        end

        // R4: next while idle has no effect
        src_empty = '1;
        dn_next   = 1'b1;
        #1;
        chk("R4 next ignored while idle", 32'(src_start), 0);
        tick();
        dn_next = 1'b0;
        chk("R4 idle next leaves no offer", 32'(dn_pending), 0);

        // R8: back-to-back requesters, pointer at 2 -> grant 0, then 1
        do_xfer(4'b1100, 0, 2, 9, 1'b1, 1);

        // R9: withdraw keeps the pointer (at 1)
        src_empty = 4'b1001;
        tick();
        chk("R9 offer before withdraw", 32'(dn_pending), 1);
        chk("R9 grant before withdraw", 32'(grant_idx), 1);
        src_empty = '1;
        tick();
        chk("R9 offer gone after withdraw", 32'(dn_pending), 0);
        chk("R9 no start after withdraw", 32'(src_start), 0);
        do_xfer(4'b1001, 1, 2, 10, 1'b0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule